// File: doc/BRIEF.md
# Inversion-Coded Link Encoder and Decoder

This block sits on a W-bit on-chip network link. It lowers switching and crosstalk activity between neighbouring wires. Each accepted flit is first converted to Gray code. The Gray word is then compared, wire pair by wire pair, against the word currently driven on the link. Each adjacent pair of lines is classified by the kind of transition it would make. Three counts are kept: pairs that toggle together in the same direction, pairs that toggle in opposite directions, and pairs where only the even-indexed line toggles.

A decision stage turns the three counts into one of four inversion modes. The mode is applied as an XOR mask, and the masked word is driven on the link with a two-bit mode flag. The link register itself is the history for the next comparison. The matching decoder removes the mask named by the flag, undoes the Gray code and returns the original data.

The flow is valid-only, with no backpressure. Idle cycles leave the link lines untouched.

Top module: `icl_link_codec`

## Requirements
- R1: While reset is asserted, `link_valid`, `out_valid`, `link_word`, `link_flag` and `out_data` are all zero. The history word used for comparison therefore starts at zero.
- R2: A flit presented with `in_valid` high at clock edge k appears with `link_valid` high after edge k+2. It appears with `out_valid` high after edge k+3. Cycles without `in_valid` give low valid outputs at the same offsets.
- R3: Every flit's `out_data` equals its `in_data` bit for bit.
- R4: The link word is `g ^ mask`, with Gray word `g = d ^ (d >> 1)` and `mask` chosen by `link_flag`:
  - 2'b00: zero.
  - 2'b01: ones at odd bit positions 1, 3, 5, ….
  - 2'b10: ones at even bit positions 0, 2, 4, ….
  - 2'b11: all ones.
- R5: Pair p covers lines p and p+1, for p = 0 … W-2. Each pair is compared between the current link word (old) and the new Gray word (new):
  - "aligned": both lines toggle and the old bits are equal.
  - "opposed": both lines toggle and the old bits differ.
  - "even-only": exactly one line toggles, and it is the line with the even index.
  - A count is in the majority when twice the count is greater than W-1.
- R6: If the aligned count is in the majority, the flag is 2'b11 (full inversion). This rule has the highest priority.
- R7: Otherwise, if the opposed count is in the majority, the flag is 2'b01 (odd inversion).
- R8: Otherwise, if the even-only count is in the majority, the flag is 2'b10 (even inversion).
- R9: Otherwise the flag is 2'b00 and the Gray word is sent unmasked.
- R10: In cycles where no flit reaches the link, `link_word` and `link_flag` keep their values. The comparison history only advances on flits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A flit is offered this cycle |
| in_data | input | W | Flit payload in binary |
| link_valid | output | 1 | Link carries a new flit |
| link_word | output | W | Masked Gray word on the link lines |
| link_flag | output | 2 | Inversion mode flag sent beside the word |
| out_valid | output | 1 | Decoded flit available |
| out_data | output | W | Decoded binary payload |

## Verification
The bound checker watches the timing on every cycle:
- the two-cycle and one-cycle valid offsets;
- the three-cycle round trip from `in_data` to `out_data`;
- the frozen link lines during idle cycles.

The mode decision is shown only by the bench's scenarios. A bench model recomputes the pair counts against its own copy of the history, and directed flits are built from that history to force each of the four modes. The bench also confirms that each mode actually appeared on the link.

// File: rtl/icl_pkg.sv
package icl_pkg;

    // Inversion mode, also the two flag bits sent with the link word.
    typedef enum logic [1:0] {
        INV_NONE = 2'b00,
        INV_ODD  = 2'b01,
        INV_EVEN = 2'b10,
        INV_FULL = 2'b11
    } inv_mode_e;

    // Kind of transition an adjacent line pair makes.
    typedef enum logic [1:0] {
        PAIR_IDLE,      // neither line toggles
        PAIR_SINGLE,    // one line toggles
        PAIR_OPPOSED,   // both toggle, opposite directions
        PAIR_ALIGNED    // both toggle, same direction
    } pair_kind_e;

endpackage

// File: rtl/icl_gray_stage.sv
module icl_gray_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         s1_valid,
    output logic [W-1:0] s1_gray
);

    logic [W-1:0] gray_next;

    assign gray_next = in_data ^ (in_data >> 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_gray  <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_gray <= gray_next;
            end
        end
    end

endmodule

// File: rtl/icl_pair_classifier.sv
module icl_pair_classifier
    import icl_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  prev_word,
    input  logic [W-1:0]  next_word,
    output logic [CW-1:0] cnt_aligned,
    output logic [CW-1:0] cnt_opposed,
    output logic [CW-1:0] cnt_even_only
);

    localparam int PAIRS = W - 1;

    logic [PAIRS-1:0] is_aligned;
    logic [PAIRS-1:0] is_opposed;
    logic [PAIRS-1:0] is_even_only;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        localparam int EV = (p % 2 == 0) ? p : p + 1;
        localparam int OD = (p % 2 == 0) ? p + 1 : p;

        logic       tog_even;
        logic       tog_odd;
        logic       old_equal;
        pair_kind_e kind;

        assign tog_even  = prev_word[EV] ^ next_word[EV];
        assign tog_odd   = prev_word[OD] ^ next_word[OD];
        assign old_equal = (prev_word[EV] == prev_word[OD]);

        always_comb begin
            unique case ({tog_even, tog_odd})
                2'b00:   kind = PAIR_IDLE;
                2'b01,
                2'b10:   kind = PAIR_SINGLE;
                default: kind = old_equal ? PAIR_ALIGNED : PAIR_OPPOSED;
            endcase
        end

        assign is_aligned[p]   = (kind == PAIR_ALIGNED);
        assign is_opposed[p]   = (kind == PAIR_OPPOSED);
        assign is_even_only[p] = (kind == PAIR_SINGLE) && tog_even;
    end

    always_comb begin
        cnt_aligned   = '0;
        cnt_opposed   = '0;
        cnt_even_only = '0;
        for (int p = 0; p < PAIRS; p++) begin
            cnt_aligned   = cnt_aligned   + CW'(is_aligned[p]);
            cnt_opposed   = cnt_opposed   + CW'(is_opposed[p]);
            cnt_even_only = cnt_even_only + CW'(is_even_only[p]);
        end
    end

endmodule

// File: rtl/icl_mode_select.sv
module icl_mode_select
    import icl_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = $clog2(W) + 1
) (
    input  logic [CW-1:0] cnt_aligned,
    input  logic [CW-1:0] cnt_opposed,
    input  logic [CW-1:0] cnt_even_only,
    output inv_mode_e     mode,
    output logic [W-1:0]  mask
);

    localparam int PAIRS = W - 1;

    logic maj_aligned;
    logic maj_opposed;
    logic maj_even;

    assign maj_aligned = (int'(cnt_aligned)   * 2) > PAIRS;
    assign maj_opposed = (int'(cnt_opposed)   * 2) > PAIRS;
    assign maj_even    = (int'(cnt_even_only) * 2) > PAIRS;

    // Priority: full, then odd, then even, then none.
    always_comb begin
        casez ({maj_aligned, maj_opposed, maj_even})
            3'b1??:  mode = INV_FULL;
            3'b01?:  mode = INV_ODD;
            3'b001:  mode = INV_EVEN;
            default: mode = INV_NONE;
        endcase
    end

    for (genvar b = 0; b < W; b++) begin : g_mask
        if (b % 2 == 1) begin : g_odd_pos
            assign mask[b] = (mode == INV_FULL) || (mode == INV_ODD);
        end else begin : g_even_pos
            assign mask[b] = (mode == INV_FULL) || (mode == INV_EVEN);
        end
    end

endmodule

// File: rtl/icl_link_decoder.sv
module icl_link_decoder
    import icl_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         link_valid,
    input  logic [W-1:0] link_word,
    input  logic [1:0]   link_flag,
    output logic         out_valid,
    output logic [W-1:0] out_data
);

    logic [W-1:0] unmask;
    logic [W-1:0] gray_word;
    logic [W-1:0] bin_word;

    for (genvar b = 0; b < W; b++) begin : g_unmask
        if (b % 2 == 1) begin : g_odd_pos
            assign unmask[b] = (link_flag == INV_FULL) || (link_flag == INV_ODD);
        end else begin : g_even_pos
            assign unmask[b] = (link_flag == INV_FULL) || (link_flag == INV_EVEN);
        end
    end

    assign gray_word = link_word ^ unmask;

    always_comb begin
        bin_word[W-1] = gray_word[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_word[i] = bin_word[i+1] ^ gray_word[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= link_valid;
            if (link_valid) begin
                out_data <= bin_word;
            end
        end
    end

endmodule

// File: rtl/icl_link_codec.sv
module icl_link_codec
    import icl_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         link_valid,
    output logic [W-1:0] link_word,
    output logic [1:0]   link_flag,
    output logic         out_valid,
    output logic [W-1:0] out_data
);

    localparam int CW = $clog2(W) + 1;

    logic          s1_valid;
    logic [W-1:0]  s1_gray;
    logic [CW-1:0] cnt_aligned;
    logic [CW-1:0] cnt_opposed;
    logic [CW-1:0] cnt_even_only;
    inv_mode_e     mode;
    logic [W-1:0]  mask;

    icl_gray_stage #(.W(W)) u_gray (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .s1_valid (s1_valid),
        .s1_gray  (s1_gray)
    );

    // The link register doubles as the comparison history.
    icl_pair_classifier #(.W(W), .CW(CW)) u_class (
        .prev_word     (link_word),
        .next_word     (s1_gray),
        .cnt_aligned   (cnt_aligned),
        .cnt_opposed   (cnt_opposed),
        .cnt_even_only (cnt_even_only)
    );

    icl_mode_select #(.W(W), .CW(CW)) u_sel (
        .cnt_aligned   (cnt_aligned),
        .cnt_opposed   (cnt_opposed),
        .cnt_even_only (cnt_even_only),
        .mode          (mode),
        .mask          (mask)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_valid <= 1'b0;
            link_word  <= '0;
            link_flag  <= INV_NONE;
        end else begin
            link_valid <= s1_valid;
            if (s1_valid) begin
                link_word <= s1_gray ^ mask;
                link_flag <= mode;
            end
        end
    end

    icl_link_decoder #(.W(W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_valid (link_valid),
        .link_word  (link_word),
        .link_flag  (link_flag),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

endmodule

// File: rtl/icl_link_codec_chk.sv
module icl_link_codec_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] in_data,
    input logic         link_valid,
    input logic [W-1:0] link_word,
    input logic [1:0]   link_flag,
    input logic         out_valid,
    input logic [W-1:0] out_data
);

    // Cycles since reset release, saturating, so no $past reaches into reset.
    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= 2'd0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    a_r2_link_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> (link_valid == $past(in_valid, 2)));

    a_r2_out_follows_link: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd1) |-> (out_valid == $past(link_valid)));

    a_r3_round_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && out_valid) |-> (out_data == $past(in_data, 3)));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd1 && !link_valid) |-> ($stable(link_word) && $stable(link_flag)));

endmodule

bind icl_link_codec icl_link_codec_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .link_valid (link_valid),
    .link_word  (link_word),
    .link_flag  (link_flag),
    .out_valid  (out_valid),
    .out_data   (out_data)
);

// File: tb/test_icl_link_codec.sv
module test_icl_link_codec;

    localparam int W          = 8;
    localparam int PAIRS      = W - 1;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [W-1:0] in_data;
    logic         link_valid;
    logic [W-1:0] link_word;
    logic [1:0]   link_flag;
    logic         out_valid;
    logic [W-1:0] out_data;

    always #(CLK_PERIOD / 2) clk = ~clk;

    icl_link_codec #(.W(W)) i_icl_link_codec (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .link_valid (link_valid),
        .link_word  (link_word),
        .link_flag  (link_flag),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

    int           checks = 0;
    int           errors = 0;
    int           m      = 3;
    bit           done   = 0;
    logic         hv [4] = '{default: 1'b0};
    logic [W-1:0] hd [4] = '{default: '0};
    logic [W-1:0] mprev    = '0;
    logic [W-1:0] exp_word = '0;
    logic [1:0]   exp_flag = 2'b00;
    int           hits [4] = '{default: 0};

    function automatic logic [W-1:0] to_gray(logic [W-1:0] d);
        return d ^ (d >> 1);
    endfunction

    function automatic logic [W-1:0] from_gray(logic [W-1:0] g);
        logic [W-1:0] b;
        b[W-1] = g[W-1];
        for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    // R5: pair counts and strict majority; R6-R9 priority of the decision.
    function automatic logic [1:0] pick_mode(logic [W-1:0] old_w, logic [W-1:0] new_w);
        int al = 0, op = 0, ev = 0;
        for (int p = 0; p < PAIRS; p++) begin
            bit ta  = old_w[p] ^ new_w[p];
            bit tb  = old_w[p+1] ^ new_w[p+1];
            bit lo_even = (p % 2 == 0);
            if (ta && tb) begin
                if (old_w[p] == old_w[p+1]) al++;
                else op++;
            end else if (ta && !tb && lo_even) begin
                ev++;
            end else if (tb && !ta && !lo_even) begin
                ev++;
            end
        end
        if (al * 2 > PAIRS) return 2'b11;
        if (op * 2 > PAIRS) return 2'b01;
        if (ev * 2 > PAIRS) return 2'b10;
        return 2'b00;
    endfunction

    function automatic logic [W-1:0] mask_of(logic [1:0] f);
        logic [W-1:0] mk;
        for (int b = 0; b < W; b++) begin
            mk[b] = (f == 2'b11) || (f == 2'b01 && b % 2 == 1) || (f == 2'b10 && b % 2 == 0);
        end
        return mk;
    endfunction

    function automatic string mode_tag(logic [1:0] f);
        case (f)
            2'b11:   return "R5 R6 full";
            2'b01:   return "R5 R7 odd";
            2'b10:   return "R5 R8 even";
            default: return "R5 R9 none";
        endcase
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic do_checks();
        int    li = (m - 2) % 4;
        int    oi = (m - 3) % 4;
        string tag;
        if (hv[li]) begin
            logic [W-1:0] g;
            logic [1:0]   f;
            g        = to_gray(hd[li]);
            f        = pick_mode(mprev, g);
            exp_word = g ^ mask_of(f);
            exp_flag = f;
            mprev    = exp_word;
            hits[f]++;
            tag = mode_tag(f);
        end
        check(link_valid == hv[li], "R2 link_valid", 32'(link_valid), 32'(hv[li]));
        if (hv[li]) begin
            check(link_flag == exp_flag, tag, 32'(link_flag), 32'(exp_flag));
            check(link_word == exp_word, "R4 link_word", 32'(link_word), 32'(exp_word));
        end else begin
            check(link_word == exp_word, "R10 idle word", 32'(link_word), 32'(exp_word));
            check(link_flag == exp_flag, "R10 idle flag", 32'(link_flag), 32'(exp_flag));
        end
        check(out_valid == hv[oi], "R2 out_valid", 32'(out_valid), 32'(hv[oi]));
        if (hv[oi]) begin
            check(out_data == hd[oi], "R3 out_data", 32'(out_data), 32'(hd[oi]));
        end
    endtask

    task automatic tick(logic v, logic [W-1:0] d);
        @(negedge clk);
        do_checks();
        in_valid  = v;
        in_data   = d;
        hv[m % 4] = v;
        hd[m % 4] = d;
        m++;
    endtask

    // Builds a flit from the model history that yields the wanted mode.
    task automatic send_for_mode(logic [1:0] target);
        tick(1'b0, '0);
        tick(1'b0, '0);
        for (int a = 0; a < 64; a++) begin
            logic [W-1:0] t;
            logic [W-1:0] g;
            case (target)
                2'b00:   t = '0;
                2'b10:   t = mask_of(2'b10);
                default: t = '1;
            endcase
            g = mprev ^ t;
            if (pick_mode(mprev, g) == target) begin
                tick(1'b1, from_gray(g));
                return;
            end
            tick(1'b1, W'($urandom));
            tick(1'b0, '0);
            tick(1'b0, '0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog: actual=%0h expected=%0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1c1));
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_data  = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(link_valid == 1'b0, "R1 link_valid", 32'(link_valid), 0);
        check(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 0);
        check(link_word == '0, "R1 link_word", 32'(link_word), 0);
        check(link_flag == 2'b00, "R1 link_flag", 32'(link_flag), 0);
        check(out_data == '0, "R1 out_data", 32'(out_data), 0);
        rst_n = 1'b1;

        // Directed corners: zero, all-ones, back to back, alternating.
        tick(1'b1, '0);
        tick(1'b1, '1);
        tick(1'b1, '1);
        tick(1'b1, '0);
        tick(1'b1, {(W/2){2'b10}});
        tick(1'b1, {(W/2){2'b01}});
        tick(1'b0, '0);

        for (int r = 0; r < 8; r++) begin
            send_for_mode(2'b11);
            send_for_mode(2'b01);
            send_for_mode(2'b10);
            send_for_mode(2'b00);
        end

        // Constrained random stream, about three flits in four cycles.
        for (int k = 0; k < 3000; k++) begin
            tick(($urandom % 4) != 0, W'($urandom));
        end

        repeat (4) tick(1'b0, '0);

        check(hits[3] > 0, "R6 full mode seen", 32'(hits[3]), 1);
        check(hits[1] > 0, "R7 odd mode seen", 32'(hits[1]), 1);
        check(hits[2] > 0, "R8 even mode seen", 32'(hits[2]), 1);
        check(hits[0] > 0, "R9 no-inversion mode seen", 32'(hits[0]), 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule